// File: doc/BRIEF.md
# I2C Master Transmit Queue Engine

This block is the transmit side of an I2C master. Software loads bytes into a 64-entry queue by writing a data register. Once the address phase of a transfer has finished, the engine hands the bytes one at a time to a shared bit-level engine. After each byte it reads back the acknowledge slot. Software sees three outputs: a status image of the queue, a sticky interrupt-flag image, and a control/status image. A flush control drops every queued byte at once.

When the target does not acknowledge a byte, transmission stops and the NAK is flagged. The unsent bytes stay in the queue. Nothing more goes out until software flushes the queue, so software chooses what happens to the leftover data. The "queue drained" flag is raised only after the acknowledge slot of the last byte has closed, not when that byte leaves the queue.

Top module: `i2c_txq_engine`

## Requirements
- R1: With the enable bit set, each write to the data register (offset 0x28) stores one byte. The byte engine receives the bytes in the order they were written. The queue holds 64 bytes.
- R2: While the enable bit is clear, writes to the data register are ignored and the queue stays empty.
- R3: A write into a full queue is dropped and sets the overflow flag (interrupt image bit 2). The 64 bytes already stored are unaffected.
- R4: No byte is offered to the byte engine while `addr_done_i` is low.
- R5: Once `byte_valid_o` rises, it stays high with `byte_data_o` unchanged until `byte_ready_i` accepts the byte. Exactly one byte leaves the queue per acceptance.
- R6: A byte that completes with `byte_nak_i` high has three effects. It sets interrupt bit 0 and control/status bit 3. It stops all further offers. The unsent bytes stay queued, so status bit 4 stays 0.
- R7: Writing the control register (offset 0x3C) stores bit 6 as the enable. If bit 7 is 1, the write also empties the queue in that cycle, clears control/status bit 3 and ends the NAK halt. Bit 7 always reads back as 0.
- R8: Interrupt bit 1 (queue drained) is set when a byte completes with an acknowledge and the queue is empty. It is still 0 in the cycles after the last byte is accepted and before that byte completes.
- R9: Writing ones to the interrupt register (offset 0x48) clears the matching bits of the interrupt image. If a clear and a new event hit the same bit in the same cycle, the event wins.
- R10: Queue status bit 4 is 1 exactly when the queue holds no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| addr_done_i | input | 1 | Address phase finished, data may flow |
| byte_valid_o | output | 1 | A byte is offered to the bit engine |
| byte_data_o | output | 8 | Offered byte |
| byte_ready_i | input | 1 | Bit engine accepts the offered byte |
| byte_done_i | input | 1 | Acknowledge slot of the accepted byte has finished |
| byte_nak_i | input | 1 | Acknowledge slot result, 1 = not acknowledged (valid with byte_done_i) |
| isr_o | output | 3 | Interrupt image: bit0 NAK, bit1 drained, bit2 overflow |
| fifo_stat_o | output | 8 | Queue status: bit4 empty, other bits 0 |
| ctl_stat_o | output | 8 | Control/status: bit3 NAK seen, bit6 enable, bit7 reads 0 |

## Verification
The assertions rely on the bit engine following the handshake. It raises `byte_done_i` only once per accepted byte, after the acceptance. It never asserts `byte_ready_i` in a cycle in which a flush is written. The bench's engine model follows this order: it offers ready for exactly one cycle and waits a fixed delay before completing. All flushes are issued while the model is idle or after a NAK has halted the queue.

// File: rtl/i2c_txq_pkg.sv
package i2c_txq_pkg;
    localparam logic [7:0] OFF_DATA = 8'h28;
    localparam logic [7:0] OFF_CTL  = 8'h3C;
    localparam logic [7:0] OFF_ISR  = 8'h48;

    localparam int CTL_EN_BIT    = 6;
    localparam int CTL_FLUSH_BIT = 7;
    localparam int CTL_NAK_BIT   = 3;
    localparam int STAT_EMPTY_BIT = 4;

    localparam int ISR_NAK  = 0;
    localparam int ISR_DRN  = 1;
    localparam int ISR_OVF  = 2;
    localparam int ISR_W    = 3;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_OFFER = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_e;
endpackage

// File: rtl/i2c_txq_fifo.sv
module i2c_txq_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == FULLC);
    assign head_o  = mem_q[q.rd];

    always_comb begin
        d       = q;
        push_ok = push_i && !full_o && !flush_i;
        pop_ok  = pop_i && !empty_o && !flush_i;
        if (flush_i) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (push_ok) d.wr = (q.wr == LAST) ? '0 : q.wr + 1'b1;
            if (pop_ok)  d.rd = (q.rd == LAST) ? '0 : q.rd + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) mem_q[q.wr] <= data_i;
    end

    assert_pop_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);
    assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= FULLC);
    assert_full_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full_o && !pop_i && !flush_i) |=> full_o);
    assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> empty_o);
endmodule

// File: rtl/i2c_txq_seq.sv
module i2c_txq_seq
    import i2c_txq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic go_i,
    input  logic fifo_empty_i,
    input  logic flush_i,
    input  logic byte_ready_i,
    input  logic byte_done_i,
    input  logic byte_nak_i,
    output logic pop_o,
    output logic byte_valid_o,
    output logic nak_event_o,
    output logic drained_o
);
    typedef struct packed {
        sq_state_e st;
        logic      halt;
    } seq_st_t;

    seq_st_t q, d;

    assign byte_valid_o = (q.st == SQ_OFFER) && !fifo_empty_i && !flush_i;

    always_comb begin
        d           = q;
        pop_o       = 1'b0;
        nak_event_o = 1'b0;
        drained_o   = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (enable_i && go_i && !fifo_empty_i && !q.halt && !flush_i)
                    d.st = SQ_OFFER;
            end
            SQ_OFFER: begin
                if (fifo_empty_i || flush_i) begin
                    d.st = SQ_IDLE;
                end else if (byte_ready_i) begin
                    pop_o = 1'b1;
                    d.st  = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (byte_done_i) begin
                    d.st = SQ_IDLE;
                    if (byte_nak_i) begin
                        d.halt      = 1'b1;
                        nak_event_o = 1'b1;
                    end else if (fifo_empty_i) begin
                        drained_o = 1'b1;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        if (flush_i) d.halt = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: SQ_IDLE, halt: 1'b0};
        else         q <= d;
    end

    assert_halt_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.halt |-> !byte_valid_o);
    assert_offer_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_o && !byte_ready_i && !flush_i) |=> byte_valid_o);
    assert_no_go_no_offer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == SQ_IDLE && !go_i) |=> !byte_valid_o);
endmodule

// File: rtl/i2c_txq_engine.sv
module i2c_txq_engine
    import i2c_txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_we_i,
    input  logic [7:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic             addr_done_i,
    output logic             byte_valid_o,
    output logic [WIDTH-1:0] byte_data_o,
    input  logic             byte_ready_i,
    input  logic             byte_done_i,
    input  logic             byte_nak_i,
    output logic [ISR_W-1:0] isr_o,
    output logic [7:0]       fifo_stat_o,
    output logic [7:0]       ctl_stat_o
);
    typedef struct packed {
        logic             en;
        logic             cs_nak;
        logic [ISR_W-1:0] isr;
    } top_st_t;

    top_st_t q, d;
    logic data_hit, ctl_hit, flush, overflow;
    logic fifo_empty, fifo_full, pop, nak_ev, drained;
    logic [ISR_W-1:0] isr_clr, isr_set;

    assign data_hit = reg_we_i && (reg_addr_i == OFF_DATA) && q.en;
    assign ctl_hit  = reg_we_i && (reg_addr_i == OFF_CTL);
    assign flush    = ctl_hit && reg_wdata_i[CTL_FLUSH_BIT];
    assign overflow = data_hit && fifo_full;
    assign isr_clr  = (reg_we_i && reg_addr_i == OFF_ISR) ? reg_wdata_i[ISR_W-1:0] : '0;

    always_comb begin
        d = q;
        isr_set = '0;
        isr_set[ISR_NAK] = nak_ev;
        isr_set[ISR_DRN] = drained;
        isr_set[ISR_OVF] = overflow;
        if (ctl_hit) d.en = reg_wdata_i[CTL_EN_BIT];
        if (nak_ev)      d.cs_nak = 1'b1;
        else if (flush)  d.cs_nak = 1'b0;
        d.isr = (q.isr & ~isr_clr) | isr_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    i2c_txq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (data_hit),
        .data_i  (reg_wdata_i[WIDTH-1:0]),
        .pop_i   (pop),
        .flush_i (flush),
        .head_o  (byte_data_o),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    i2c_txq_seq u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enable_i     (q.en),
        .go_i         (addr_done_i),
        .fifo_empty_i (fifo_empty),
        .flush_i      (flush),
        .byte_ready_i (byte_ready_i),
        .byte_done_i  (byte_done_i),
        .byte_nak_i   (byte_nak_i),
        .pop_o        (pop),
        .byte_valid_o (byte_valid_o),
        .nak_event_o  (nak_ev),
        .drained_o    (drained)
    );

    assign isr_o = q.isr;

    always_comb begin
        fifo_stat_o = '0;
        fifo_stat_o[STAT_EMPTY_BIT] = fifo_empty;
        ctl_stat_o = '0;
        ctl_stat_o[CTL_NAK_BIT] = q.cs_nak;
        ctl_stat_o[CTL_EN_BIT]  = q.en;
    end

    assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_o && !byte_ready_i && !flush) |=> $stable(byte_data_o));
    assert_ovf_from_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(isr_o[ISR_OVF]) |-> $past(reg_we_i));
    assert_nak_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_done_i && byte_nak_i && !flush) |=> (isr_o[ISR_NAK] && ctl_stat_o[CTL_NAK_BIT]));
    assert_flush_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_stat_o[CTL_FLUSH_BIT]);
endmodule

// File: tb/test_i2c_txq_engine.sv
module test_i2c_txq_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic addr_done = 1'b0;
    logic byte_valid, byte_ready = 1'b0, byte_done = 1'b0, byte_nak = 1'b0;
    logic [7:0] byte_data;
    logic [2:0] isr;
    logic [7:0] fstat, cstat;

    int checks = 0, errs = 0;
    int sent = 0;
    int nak_at = -1;
    int phase = 0, dly = 0;
    bit last_pending = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    i2c_txq_engine i_i2c_txq_engine (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .addr_done_i(addr_done), .byte_valid_o(byte_valid),
        .byte_data_o(byte_data), .byte_ready_i(byte_ready), .byte_done_i(byte_done),
        .byte_nak_i(byte_nak), .isr_o(isr), .fifo_stat_o(fstat), .ctl_stat_o(cstat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    // driver: pushes a byte and records it as expected when it will be stored
    task automatic push(input logic [7:0] v, input bit expect_it);
        if (expect_it) exp_q.push_back(v);
        wr(8'h28, v);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 3000 && (exp_q.size() != 0 || phase != 0); i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // bit engine model and scoreboard monitor
    always @(negedge clk) begin
        byte_done = 1'b0;
        byte_nak  = 1'b0;
        if (!rst_n) begin
            phase = 0; byte_ready = 1'b0;
        end else if (phase == 1) begin
            byte_ready = 1'b0;
            phase = 2; dly = 3;
            if (last_pending)
                chk(isr[1] == 1'b0, "R8 drained not at pop", isr[1], 0);
        end else if (phase == 2) begin
            if (dly == 0) begin
                byte_done = 1'b1;
                byte_nak  = (sent - 1 == nak_at);
                phase = 0;
            end else dly--;
        end else if (byte_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected byte", byte_data, 0);
            end else begin
                chk(byte_data == exp_q[0], "R1/R5 byte order", byte_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
            last_pending = (exp_q.size() == 0);
            sent++;
            byte_ready = 1'b1;
            phase = 1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(isr == 3'b000, "reset isr", isr, 0);
        chk(fstat[4] == 1'b1, "R10 reset empty", fstat[4], 1);
        chk(byte_valid == 1'b0 && cstat[3] == 1'b0, "reset idle", byte_valid, 0);

        // R2: disabled writes ignored
        push(8'h11, 1'b0);
        push(8'h22, 1'b0);
        @(negedge clk);
        chk(fstat[4] == 1'b1, "R2 disabled write ignored", fstat[4], 1);

        // enable, address phase not done: R4
        wr(8'h3C, 8'h40);
        chk(cstat[6] == 1'b1 && cstat[7] == 1'b0, "R7 enable readback", cstat, 8'h40);
        push(8'hA1, 1'b1); push(8'hB2, 1'b1); push(8'hC3, 1'b1);
        repeat (20) @(negedge clk);
        chk(sent == 0 && byte_valid == 1'b0, "R4 held without address phase", sent, 0);
        chk(fstat[4] == 1'b0, "R10 not empty", fstat[4], 0);

        addr_done = 1'b1;
        wait_drain();
        chk(sent == 3, "R1 three bytes sent", sent, 3);
        chk(isr[1] == 1'b1, "R8 drained flag", isr, 2);
        chk(fstat[4] == 1'b1, "R10 empty after drain", fstat[4], 1);

        wr(8'h48, 8'h02);
        chk(isr[1] == 1'b0, "R9 write-one clear", isr, 0);

        // R3: overflow
        addr_done = 1'b0;
        for (int i = 0; i < 65; i++) push(8'(i * 3 + 1), i < 64);
        @(negedge clk);
        chk(isr[2] == 1'b1, "R3 overflow flag", isr, 4);
        wr(8'h48, 8'h04);
        chk(isr[2] == 1'b0, "R9 clear overflow", isr, 0);
        base = sent;
        addr_done = 1'b1;
        wait_drain();
        chk(sent - base == 64, "R3 64 bytes kept", sent - base, 64);
        wr(8'h48, 8'h07);

        // R6: NAK on the second of four bytes
        base = sent;
        nak_at = base + 1;
        push(8'h51, 1'b1); push(8'h52, 1'b1); push(8'h53, 1'b1); push(8'h54, 1'b1);
        repeat (40) @(negedge clk);
        chk(sent - base == 2, "R6 halted after nak", sent - base, 2);
        chk(isr[0] == 1'b1 && cstat[3] == 1'b1, "R6 nak flags", {isr, cstat}, 1);
        chk(fstat[4] == 1'b0, "R6 bytes retained", fstat[4], 0);
        chk(byte_valid == 1'b0, "R6 no offer while halted", byte_valid, 0);
        chk(isr[1] == 1'b0, "R8 no drain on nak", isr[1], 0);

        // R7: flush
        nak_at = -1;
        exp_q.delete();
        wr(8'h3C, 8'hC0);
        chk(fstat[4] == 1'b1, "R7 flush empties", fstat[4], 1);
        chk(cstat[3] == 1'b0 && cstat[7] == 1'b0 && cstat[6] == 1'b1, "R7 ctl after flush", cstat, 8'h40);
        chk(isr[0] == 1'b1, "R9 nak stays until cleared", isr, 1);
        base = sent;
        push(8'h61, 1'b1); push(8'h62, 1'b1);
        wait_drain();
        chk(sent - base == 2, "R7 resumes after flush", sent - base, 2);
        chk(isr[1] == 1'b1, "R8 drained after resume", isr, 3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule